// File: doc/BRIEF.md
# Multi-Accumulator Transport ALU

This unit carries out arithmetic and logic work in a move-only processor, where the operation is chosen by the address a value is written to and not by an opcode. A write strobe presents an 8-bit destination code and a 16-bit source value. When the destination falls in the plain arithmetic range or the test range, one of four 16-bit accumulators is combined with the source and overwritten with the result. Every other destination is ignored, because register, memory and transfer destinations are handled elsewhere.

The plain range changes only the accumulator. The test range also updates the zero, carry and minus flags, which go to the branch unit together with all four accumulators for conditional transfers. Results and flags appear on the outputs one clock after the write.

Top module: `tta_alu`

## Requirements
- R1: While rst_ni is low, all four accumulators and the zero, carry and minus flags are 0.
- R2: Destination bits [1:0] pick the accumulator. Only that accumulator changes, and the new value is visible on acc_o (accumulator k at bits [16k+15:16k]) after the rising clock edge that samples wr_en_i high.
- R3: Destinations 100ooo_aa (binary) are the plain group. For ooo = 0..7 the new value is: source; acc AND source; acc + source mod 2^16; acc - source mod 2^16; acc XOR source; acc rotated left; acc OR source; NOT source. The plain group never changes any flag.
- R4: Destinations 101ooo_aa are the test group. For ooo = 0 (load source), 1 (acc AND source) and 4 (acc OR source with its two bytes exchanged) the carry flag keeps its value.
- R5: Test ooo = 2 writes acc + source and ooo = 6 writes acc + source + carry. Carry becomes the unsigned carry out of bit 15.
- R6: Test ooo = 3 writes acc - source and ooo = 7 writes acc - source - (NOT carry). Carry becomes 1 exactly when no borrow occurred.
- R7: Test ooo = 5 forms the 17-bit sum acc + source and writes bits [16:1] of it. Carry becomes bit 0 of the sum.
- R8: After every test-group write, zero_o is 1 exactly when the 16-bit result is 0, and minus_o equals bit 15 of the result.
- R9: A destination whose bit 7 is 0, or whose bits [7:6] are 11, changes neither the accumulators nor the flags. With wr_en_i low nothing changes.
- R10: The plain rotate (ooo = 5) moves bits toward bit 15, with bit 15 wrapping into bit 0. The count is source bits [3:0], so a source of 0 or 16 leaves the accumulator unchanged and 17 rotates by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one move |
| dst_i | input | 8 | Destination code of the move |
| src_i | input | 16 | Source value of the move |
| acc_o | output | 64 | Four accumulators, accumulator k in bits [16k+15:16k] |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |
| minus_o | output | 1 | Minus flag |

## Verification
The hardest cases to reach are the carry-chained forms: add with carry and subtract with borrow only show their effect when a specific carry value is left over from an earlier test operation. Each chained operation is therefore preceded by a test-group add, subtract or load that sets the carry to a known value. A test load is used to change an accumulator in between, because it keeps the carry. Shift right with add needs a sum that overflows 16 bits to show carry-out reaching bit 15, so operands near 0xFFFF are loaded first. The rotate count is checked at its wrap points 0, 16 and 17.

// File: rtl/tta_alu_pkg.sv
package tta_alu_pkg;
  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_PLAIN = 2'd1,
    GRP_TEST  = 2'd2
  } grp_e;

  localparam logic [2:0] PFX_PLAIN = 3'b100;
  localparam logic [2:0] PFX_TEST  = 3'b101;
endpackage

// File: rtl/tta_alu_dec.sv
module tta_alu_dec
  import tta_alu_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic [7:0]       dst_i,
  output grp_e             grp_o,
  output logic [2:0]       op_o,
  output logic [SEL_W-1:0] sel_o
);
  always_comb begin
    grp_o = GRP_NONE;
    if (dst_i[7:5] == PFX_PLAIN)     grp_o = GRP_PLAIN;
    else if (dst_i[7:5] == PFX_TEST) grp_o = GRP_TEST;
  end

  assign op_o  = dst_i[4:2];
  assign sel_o = dst_i[SEL_W-1:0];
endmodule

// File: rtl/tta_alu_exec.sv
module tta_alu_exec #(
  parameter int DATA_W = 16
) (
  input  logic              test_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              c_we_o
);
  localparam int RW   = $clog2(DATA_W);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W:0]   ext_a, ext_b, c_ext, nb_ext, sum, dif, sumc, difb;
  logic [RW:0]       rsh;
  logic [DATA_W-1:0] rol, swp;

  always_comb begin
    ext_a  = {1'b0, a_i};
    ext_b  = {1'b0, b_i};
    c_ext  = {{DATA_W{1'b0}}, c_i};
    nb_ext = {{DATA_W{1'b0}}, ~c_i};
    sum    = ext_a + ext_b;
    dif    = ext_a - ext_b;
    sumc   = sum + c_ext;
    difb   = dif - nb_ext;
    // shift by DATA_W yields 0, so a zero count keeps a_i
    rsh    = (RW+1)'(DATA_W) - {1'b0, b_i[RW-1:0]};
    rol    = (a_i << b_i[RW-1:0]) | (a_i >> rsh);
    swp    = {b_i[HALF-1:0], b_i[DATA_W-1:HALF]};
  end

  always_comb begin
    res_o  = b_i;
    c_o    = c_i;
    c_we_o = 1'b0;
    if (!test_i) begin
      unique case (op_i)
        3'd0: res_o = b_i;
        3'd1: res_o = a_i & b_i;
        3'd2: res_o = sum[DATA_W-1:0];
        3'd3: res_o = dif[DATA_W-1:0];
        3'd4: res_o = a_i ^ b_i;
        3'd5: res_o = rol;
        3'd6: res_o = a_i | b_i;
        default: res_o = ~b_i;
      endcase
    end else begin
      unique case (op_i)
        3'd0: res_o = b_i;
        3'd1: res_o = a_i & b_i;
        3'd2: begin res_o = sum[DATA_W-1:0];  c_o = sum[DATA_W];   c_we_o = 1'b1; end
        3'd3: begin res_o = dif[DATA_W-1:0];  c_o = ~dif[DATA_W];  c_we_o = 1'b1; end
        3'd4: res_o = a_i | swp;
        3'd5: begin res_o = sum[DATA_W:1];    c_o = sum[0];        c_we_o = 1'b1; end
        3'd6: begin res_o = sumc[DATA_W-1:0]; c_o = sumc[DATA_W];  c_we_o = 1'b1; end
        default: begin res_o = difb[DATA_W-1:0]; c_o = ~difb[DATA_W]; c_we_o = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/tta_alu_bank.sv
module tta_alu_bank #(
  parameter int DATA_W = 16,
  parameter int ACC_N  = 4,
  localparam int SEL_W = $clog2(ACC_N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [DATA_W-1:0]       d_i,
  output logic [DATA_W-1:0]       cur_o,
  output logic [ACC_N*DATA_W-1:0] acc_o
);
  logic [DATA_W-1:0] acc_q [ACC_N];

  for (genvar k = 0; k < ACC_N; k++) begin : g_acc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               acc_q[k] <= '0;
      else if (we_i && (sel_i == SEL_W'(k)))     acc_q[k] <= d_i;
    end
    assign acc_o[k*DATA_W +: DATA_W] = acc_q[k];
  end

  assign cur_o = acc_q[sel_i];
endmodule

// File: rtl/tta_alu.sv
module tta_alu
  import tta_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_N  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [7:0]              dst_i,
  input  logic [DATA_W-1:0]       src_i,
  output logic [ACC_N*DATA_W-1:0] acc_o,
  output logic                    zero_o,
  output logic                    carry_o,
  output logic                    minus_o
);
  localparam int SEL_W = $clog2(ACC_N);

  grp_e              grp;
  logic [2:0]        op;
  logic [SEL_W-1:0]  sel;
  logic [DATA_W-1:0] cur, res;
  logic              c_nxt, c_we, acc_we, test_we;

  tta_alu_dec #(.SEL_W(SEL_W)) u_dec (
    .dst_i (dst_i),
    .grp_o (grp),
    .op_o  (op),
    .sel_o (sel)
  );

  tta_alu_exec #(.DATA_W(DATA_W)) u_exec (
    .test_i (grp == GRP_TEST),
    .op_i   (op),
    .a_i    (cur),
    .b_i    (src_i),
    .c_i    (carry_o),
    .res_o  (res),
    .c_o    (c_nxt),
    .c_we_o (c_we)
  );

  assign acc_we  = wr_en_i && (grp != GRP_NONE);
  assign test_we = wr_en_i && (grp == GRP_TEST);

  tta_alu_bank #(.DATA_W(DATA_W), .ACC_N(ACC_N)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (acc_we),
    .sel_i  (sel),
    .d_i    (res),
    .cur_o  (cur),
    .acc_o  (acc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_o  <= 1'b0;
      carry_o <= 1'b0;
      minus_o <= 1'b0;
    end else if (test_we) begin
      zero_o  <= (res == '0);
      minus_o <= res[DATA_W-1];
      if (c_we) carry_o <= c_nxt;
    end
  end
endmodule

// File: rtl/tta_alu_chk.sv
module tta_alu_chk #(
  parameter int DATA_W = 16,
  parameter int ACC_N  = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [7:0]              dst_i,
  input logic [DATA_W-1:0]       src_i,
  input logic [ACC_N*DATA_W-1:0] acc_o,
  input logic                    zero_o,
  input logic                    carry_o,
  input logic                    minus_o
);
  localparam int SEL_W = $clog2(ACC_N);

  logic [DATA_W-1:0] acc_a [ACC_N];
  for (genvar k = 0; k < ACC_N; k++) begin : g_unp
    assign acc_a[k] = acc_o[k*DATA_W +: DATA_W];
  end

  logic plain_wr, test_wr, ign_wr, keep_c;
  assign plain_wr = wr_en_i && (dst_i[7:5] == 3'b100);
  assign test_wr  = wr_en_i && (dst_i[7:5] == 3'b101);
  assign ign_wr   = wr_en_i && (!dst_i[7] || (dst_i[7:6] == 2'b11));
  assign keep_c   = test_wr && ((dst_i[4:2] == 3'd0) || (dst_i[4:2] == 3'd1) || (dst_i[4:2] == 3'd4));

  always_comb begin
    if (!rst_ni) AST_RESET_CLEAR: assert (acc_o == '0 && !zero_o && !carry_o && !minus_o); // R1
  end

  AST_PLAIN_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (plain_wr && dst_i[4:2] == 3'd0) |=> acc_a[$past(dst_i[SEL_W-1:0])] == $past(src_i)); // R3

  AST_PLAIN_FLAGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plain_wr |=> ($stable(zero_o) && $stable(carry_o) && $stable(minus_o))); // R3

  AST_TEST_CARRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_c |=> $stable(carry_o)); // R4

  AST_ZERO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_wr |=> zero_o == (acc_a[$past(dst_i[SEL_W-1:0])] == '0)); // R8

  AST_MINUS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_wr |=> minus_o == acc_a[$past(dst_i[SEL_W-1:0])][DATA_W-1]); // R8

  AST_IGNORE_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ign_wr |=> ($stable(acc_o) && $stable(zero_o) && $stable(carry_o) && $stable(minus_o))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(acc_o) && $stable(zero_o) && $stable(carry_o) && $stable(minus_o))); // R9
endmodule

bind tta_alu tta_alu_chk #(.DATA_W(DATA_W), .ACC_N(ACC_N)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .dst_i   (dst_i),
  .src_i   (src_i),
  .acc_o   (acc_o),
  .zero_o  (zero_o),
  .carry_o (carry_o),
  .minus_o (minus_o)
);

// File: tb/sim_tta_alu.sv
`timescale 1ns/1ps
module sim_tta_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  dst = 8'h00;
  logic [15:0] src = 16'h0000;
  logic [63:0] acc;
  logic        zf, cf, mf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_acc [4];
  logic        m_z, m_c, m_m;

  always #2.5 clk = ~clk;

  tta_alu u0 (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .dst_i (dst), .src_i (src),
    .acc_o (acc), .zero_o (zf), .carry_o (cf), .minus_o (mf)
  );

  function automatic logic [7:0] pl(input int op, input int a);
    return 8'h80 | 8'(op << 2) | 8'(a);
  endfunction
  function automatic logic [7:0] ts(input int op, input int a);
    return 8'hA0 | 8'(op << 2) | 8'(a);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    for (int k = 0; k < 4; k++) chk({tag, " acc"}, acc[k*16 +: 16], m_acc[k]);
    chk({tag, " zero"},  16'(zf), 16'(m_z));
    chk({tag, " carry"}, 16'(cf), 16'(m_c));
    chk({tag, " minus"}, 16'(mf), 16'(m_m));
  endtask

  // expected result from the requirement text
  task automatic model(input logic [7:0] d, input logic [15:0] s);
    logic [15:0] a, r;
    logic [16:0] t;
    int n;
    a = m_acc[d[1:0]];
    if (d[7:5] == 3'b100) begin
      case (d[4:2])
        3'd0: r = s;
        3'd1: r = a & s;
        3'd2: r = a + s;
        3'd3: r = a - s;
        3'd4: r = a ^ s;
        3'd5: begin
          r = a; n = int'(s[3:0]);
          for (int i = 0; i < n; i++) r = {r[14:0], r[15]};
        end
        3'd6: r = a | s;
        default: r = ~s;
      endcase
      m_acc[d[1:0]] = r;
    end else if (d[7:5] == 3'b101) begin
      case (d[4:2])
        3'd0: r = s;
        3'd1: r = a & s;
        3'd2: begin t = {1'b0, a} + {1'b0, s}; r = t[15:0]; m_c = t[16]; end
        3'd3: begin r = a - s; m_c = (a >= s); end
        3'd4: r = a | {s[7:0], s[15:8]};
        3'd5: begin t = {1'b0, a} + {1'b0, s}; r = t[16:1]; m_c = t[0]; end
        3'd6: begin t = {1'b0, a} + {1'b0, s} + {16'd0, m_c}; r = t[15:0]; m_c = t[16]; end
        default: begin
          t = {1'b0, a} - {1'b0, s} - {16'd0, ~m_c};
          r = t[15:0]; m_c = ({1'b0, a} >= ({1'b0, s} + {16'd0, ~m_c}));
        end
      endcase
      m_acc[d[1:0]] = r;
      m_z = (r == 16'h0);
      m_m = r[15];
    end
  endtask

  task automatic mv(input logic [7:0] d, input logic [15:0] s, input string tag);
    @(negedge clk);
    wr_en = 1'b1; dst = d; src = s;
    model(d, s);
    @(negedge clk);
    wr_en = 1'b0;
    chk_all(tag);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 4; k++) m_acc[k] = 16'h0;
    m_z = 1'b0; m_c = 1'b0; m_m = 1'b0;
    #1;
    chk_all("R1 in reset");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after release");
  endtask

  task automatic t_plain;
    mv(pl(0, 0), 16'h1234, "R3 load a0");
    mv(pl(0, 1), 16'hF0F0, "R2 load a1");
    mv(pl(1, 1), 16'h3C3C, "R3 and");
    chk("R3 and literal", acc[31:16], 16'h3030);
    mv(pl(2, 0), 16'hFFFF, "R3 add wrap");
    chk("R3 add literal", acc[15:0], 16'h1233);
    mv(pl(3, 2), 16'h0001, "R3 sub wrap");
    chk("R3 sub literal", acc[47:32], 16'hFFFF);
    mv(pl(4, 3), 16'hA5A5, "R3 xor");
    mv(pl(6, 3), 16'h0F00, "R3 or");
    mv(pl(7, 0), 16'h00FF, "R3 not");
    chk("R3 not literal", acc[15:0], 16'hFF00);
  endtask

  task automatic t_rotate;
    mv(pl(0, 2), 16'h8001, "R10 load");
    mv(pl(5, 2), 16'h0001, "R10 rol1");
    chk("R10 rol1 literal", acc[47:32], 16'h0003);
    mv(pl(5, 2), 16'h0010, "R10 rol16");
    chk("R10 rol16 literal", acc[47:32], 16'h0003);
    mv(pl(5, 2), 16'h0011, "R10 rol17");
    chk("R10 rol17 literal", acc[47:32], 16'h0006);
    mv(pl(5, 2), 16'h0000, "R10 rol0");
    mv(pl(5, 2), 16'h000F, "R10 rol15");
    chk("R10 rol15 literal", acc[47:32], 16'h0003);
  endtask

  task automatic t_add;
    mv(ts(0, 0), 16'hFFFF, "R8 tload minus");
    chk("R8 minus set", 16'(mf), 16'h1);
    mv(ts(2, 0), 16'h0001, "R5 tadd carry");
    chk("R5 carry out", 16'(cf), 16'h1);
    chk("R8 zero set", 16'(zf), 16'h1);
    mv(ts(6, 0), 16'h0005, "R5 adc");
    chk("R5 adc literal", acc[15:0], 16'h0006);
    mv(ts(2, 3), 16'h1000, "R5 tadd no carry");
  endtask

  task automatic t_sub;
    mv(ts(0, 1), 16'h0005, "R4 tload");
    mv(ts(3, 1), 16'h0005, "R6 sub equal");
    chk("R6 no borrow", 16'(cf), 16'h1);
    mv(ts(0, 1), 16'h0003, "R4 tload keeps c");
    mv(ts(3, 1), 16'h0005, "R6 sub borrow");
    chk("R6 borrow literal", acc[31:16], 16'hFFFE);
    mv(ts(0, 1), 16'h000A, "R4 tload c0");
    mv(ts(7, 1), 16'h0003, "R6 sbb c0");
    chk("R6 sbb literal", acc[31:16], 16'h0006);
    mv(ts(7, 1), 16'h0006, "R6 sbb c1");
    chk("R6 sbb zero", 16'(zf), 16'h1);
  endtask

  task automatic t_logic;
    mv(ts(0, 2), 16'h00F0, "R4 tload");
    mv(ts(4, 2), 16'h1234, "R4 bsor");
    chk("R4 bsor literal", acc[47:32], 16'h34F2);
    mv(ts(1, 2), 16'h0000, "R4 tand zero");
    chk("R8 tand zero", 16'(zf), 16'h1);
  endtask

  task automatic t_shra;
    mv(ts(0, 3), 16'hFFFF, "R7 load");
    mv(ts(5, 3), 16'h0003, "R7 shra ovf");
    chk("R7 shra literal", acc[63:48], 16'h8001);
    chk("R7 shra c0", 16'(cf), 16'h0);
    mv(ts(0, 3), 16'h0001, "R7 load2");
    mv(ts(5, 3), 16'h0002, "R7 shra odd");
    chk("R7 shra c1", 16'(cf), 16'h1);
  endtask

  task automatic t_ignore;
    mv(8'h05, 16'hDEAD, "R9 device dst");
    mv(8'hC3, 16'hBEEF, "R9 register dst");
    mv(8'hF0, 16'h0000, "R9 memory dst");
    mv(8'h7F, 16'h0000, "R9 top device dst");
    @(negedge clk);
    dst = ts(0, 0); src = 16'h0000;
    @(negedge clk);
    chk_all("R9 no strobe");
  endtask

  initial begin
    t_reset();
    t_plain();
    t_rotate();
    t_add();
    t_sub();
    t_logic();
    t_shra();
    t_ignore();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule